// File: doc/BRIEF.md
# Oversampling Manchester Line Decoder

This block turns a Manchester-coded serial line that carries no clock into data bits. A sample-rate tick strobes the already synchronized line at a fixed multiple of the bit rate. The block measures the length of each constant-level run in samples. A run close to one half-bit length counts as one half of a bit. A run close to two half-bit lengths crosses a mid-bit boundary and counts as two halves. Pairs of halves become bits, and the bit value follows a selectable convention. A tolerance parameter sets how far a run may stray from the nominal length and still be accepted.

A frame begins on the first falling sample after the line has been sampled high. Because of this, the first half-bit of every frame is low. A frame ends in one of three ways. The line may stay high for longer than three half-bits, in which case a final bit that is still waiting for its high second half is completed. The programmed sample budget may run out, in which case a run that is still open is dropped. Or a run may fall outside both windows, which aborts the frame and raises the timing-error flag. Decoded bits shift in most significant bit first. A valid-bit count is held with the frame-done pulse.

Top module: `manch_os_decoder`

## Requirements
- R1: After reset, `bits_o`, `count_o`, `bit_valid_o`, `done_o` and `err_o` are all zero.
- R2: A frame starts only on a tick whose sample is low when the previous ticked sample in idle was high. A line held low out of reset and then raised never starts a frame.
- R3: The line is looked at only in cycles with `tick_i` high. Low levels in cycles without a tick have no effect on any output.
- R4: With HALF=6 and TOL=2, a run of 4 to 8 samples is one half-bit and a run of 10 to 14 samples is two half-bits. Any other completed run sets `err_o` and ends the frame with a `done_o` pulse. Bits decoded before that point are kept.
- R5: When `conv_i`=0, a bit whose first half is high and second half is low decodes as 1. When `conv_i`=1, a bit whose first half is low and second half is high decodes as 1.
- R6: Each decoded bit enters `bits_o` at bit 0, and earlier bits move one place up. The first bit of an n-bit frame ends at bit n-1, and `bits_o` is cleared at frame start.
- R7: `bit_valid_o` pulses for one cycle per decoded bit. `count_o` rises by one with each pulse, saturates at NBITS, is cleared at frame start, and holds the frame's bit count when `done_o` pulses.
- R8: A high run that reaches 3*HALF+1 samples ends the frame with a `done_o` pulse. If a bit is waiting for its second half at that point, it is decoded in the same cycle.
- R9: A frame covers at most `limit_i`+1 samples, counting the start sample. On the last of these samples the frame ends, and any run still open is discarded.
- R10: `err_o` rises together with a `done_o` pulse. It stays high, with no `bit_valid_o` pulse, until the next frame start clears it.
- R11: A two-half-bit run at the start of a bit, which means a bit with no mid-bit transition, sets `err_o` and ends the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_i | input | 1 | Synchronized serial line, idle high |
| tick_i | input | 1 | Sample-rate strobe |
| conv_i | input | 1 | Bit convention select (see R5) |
| limit_i | input | LIMW (8) | Frame length in samples minus one |
| bits_o | output | NBITS (32) | Decoded bit shift register |
| bit_valid_o | output | 1 | One-cycle pulse per decoded bit |
| count_o | output | clog2(NBITS+1) (6) | Bits decoded in the current frame |
| done_o | output | 1 | One-cycle frame-end pulse |
| err_o | output | 1 | Timing error in the last frame |

## Verification
The sample that completes a run, or that ends a frame, is taken at the clock edge of its tick. `bit_valid_o`, `bits_o`, `count_o`, `done_o` and `err_o` all change at that same edge. They are therefore visible exactly one cycle after the tick was presented. The bench drives line and tick on falling edges. It reads outputs on falling edges too, so every value it sees is the one registered at the preceding rising edge. Frame results are taken from the first `done_o` pulse after each frame's leading idle. Valid pulses are counted only up to that pulse, so restarts caused by a truncated frame's leftover waveform do not disturb the expected values.

// File: rtl/mdec_pkg.sv
// Shared types for the oversampling Manchester decoder.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package mdec_pkg;
    // Classification of one completed constant-level run.
    typedef enum logic [1:0] {
        RUN_BAD  = 2'd0,
        RUN_HALF = 2'd1,
        RUN_FULL = 2'd2
    } run_kind_t;

    // Frame controller state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } frame_st_t;
endpackage

// File: rtl/mdec_run_class.sv
// Classifies a run length into one half-bit, two half-bits or invalid.
// Assumes 2*TOL < HALF so that the two windows never overlap.
module mdec_run_class #(
    parameter int unsigned HALF = 6,
    parameter int unsigned TOL  = 2,
    parameter int unsigned LW   = 5
) (
    input  logic [LW-1:0]        len_i,
    output mdec_pkg::run_kind_t  kind_o
);
    import mdec_pkg::*;

    localparam logic [LW-1:0] H_LO = LW'(HALF - TOL);
    localparam logic [LW-1:0] H_HI = LW'(HALF + TOL);
    localparam logic [LW-1:0] F_LO = LW'(2*HALF - TOL);
    localparam logic [LW-1:0] F_HI = LW'(2*HALF + TOL);

    // Window compare on the measured length.
    always_comb begin
        if (len_i >= H_LO && len_i <= H_HI)      kind_o = RUN_HALF;
        else if (len_i >= F_LO && len_i <= F_HI) kind_o = RUN_FULL;
        else                                     kind_o = RUN_BAD;
    end
endmodule

// File: rtl/mdec_frame_ctl.sv
// Frame controller: detects frame start, measures run lengths, counts
// samples against the limit and decides frame end and timing errors.
// Assumes line_i is already synchronized and the line idles high.
module mdec_frame_ctl #(
    parameter int unsigned HALF = 6,
    parameter int unsigned LW   = 5,
    parameter int unsigned SW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 line_i,
    input  logic [SW-1:0]        limit_i,
    input  mdec_pkg::run_kind_t  kind_i,
    input  logic                 pair_err_i,
    output logic                 start_o,
    output logic                 run_end_o,
    output logic                 run_lvl_o,
    output logic [LW-1:0]        run_len_o,
    output logic                 flush_o,
    output logic                 done_o,
    output logic                 err_o
);
    import mdec_pkg::*;

    localparam logic [LW-1:0] RMAX = LW'(3*HALF + 1);

    frame_st_t     state_q;
    logic          last_q;
    logic          level_q;
    logic [LW-1:0] run_len_q;
    logic [SW-1:0] smp_q;
    logic          done_q;
    logic          err_q;
    logic          in_run;
    logic          same;
    logic [LW-1:0] len_inc;
    logic          bad;
    logic          hit_limit;

    // Event decode for the current tick.
    always_comb begin
        in_run    = (state_q == ST_RUN);
        same      = (line_i == level_q);
        len_inc   = (run_len_q == RMAX) ? RMAX : run_len_q + 1'b1;
        start_o   = tick_i && !in_run && last_q && !line_i;
        run_end_o = tick_i && in_run && !same;
        flush_o   = tick_i && in_run && same && level_q && (len_inc == RMAX);
        bad       = run_end_o && ((kind_i == RUN_BAD) || pair_err_i);
        hit_limit = tick_i && in_run && (smp_q == limit_i);
        run_lvl_o = level_q;
        run_len_o = run_len_q;
    end

    // Frame state, run measurement and end-of-frame flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            last_q    <= 1'b0;
            level_q   <= 1'b0;
            run_len_q <= '0;
            smp_q     <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_o) begin
                err_q     <= 1'b0;
                level_q   <= 1'b0;
                run_len_q <= LW'(1);
                smp_q     <= SW'(1);
                last_q    <= line_i;
                if (limit_i == '0) done_q  <= 1'b1;
                else               state_q <= ST_RUN;
            end else if (tick_i && !in_run) begin
                last_q <= line_i;
            end else if (tick_i && in_run) begin
                smp_q <= smp_q + 1'b1;
                if (run_end_o) begin
                    level_q   <= line_i;
                    run_len_q <= LW'(1);
                end else begin
                    run_len_q <= len_inc;
                end
                if (bad) begin
                    err_q   <= 1'b1;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                    last_q  <= line_i;
                end else if (flush_o || hit_limit) begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                    last_q  <= line_i;
                end
            end
        end
    end

    assign done_o = done_q;
    assign err_o  = err_q;
endmodule

// File: rtl/mdec_bit_asm.sv
// Bit assembler: pairs half-bit levels into bits, applies the bit
// convention and shifts bits in MSB first with a saturating count.
// Assumes runs arrive with alternating levels from the frame controller.
module mdec_bit_asm #(
    parameter int unsigned NBITS = 32,
    parameter int unsigned CW    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 conv_i,
    input  logic                 start_i,
    input  logic                 run_end_i,
    input  mdec_pkg::run_kind_t  kind_i,
    input  logic                 run_lvl_i,
    input  logic                 flush_i,
    output logic                 pair_err_o,
    output logic [NBITS-1:0]     bits_o,
    output logic [CW-1:0]        count_o,
    output logic                 valid_o
);
    import mdec_pkg::*;

    localparam logic [CW-1:0] CMAX = CW'(NBITS);

    logic             phase_q;
    logic             first_q;
    logic [NBITS-1:0] bits_q;
    logic [CW-1:0]    cnt_q;
    logic             valid_q;
    logic             emit;
    logic             ebit;

    // A bit completes on any valid run, or on flush, while a first half is held.
    always_comb begin
        pair_err_o = run_end_i && (kind_i == RUN_FULL) && !phase_q;
        emit       = phase_q && ((run_end_i && (kind_i != RUN_BAD)) || flush_i);
        ebit       = first_q ^ conv_i;
    end

    // Half-bit pairing, shift register and bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            first_q <= 1'b0;
            bits_q  <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= emit && !start_i;
            if (start_i) begin
                phase_q <= 1'b0;
                first_q <= 1'b0;
                bits_q  <= '0;
                cnt_q   <= '0;
            end else begin
                if (emit) begin
                    bits_q <= {bits_q[NBITS-2:0], ebit};
                    if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
                end
                if (run_end_i && kind_i == RUN_HALF) begin
                    if (!phase_q) begin
                        first_q <= run_lvl_i;
                        phase_q <= 1'b1;
                    end else begin
                        phase_q <= 1'b0;
                    end
                end else if (run_end_i && kind_i == RUN_FULL && phase_q) begin
                    first_q <= run_lvl_i;
                end
            end
        end
    end

    assign bits_o  = bits_q;
    assign count_o = cnt_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/manch_os_decoder.sv
// Top of the oversampling Manchester decoder. Wires the frame controller,
// run classifier and bit assembler together.
// Assumes line_i is synchronized to clk and tick_i is a one-cycle strobe.
module manch_os_decoder #(
    parameter int unsigned HALF  = 6,
    parameter int unsigned TOL   = 2,
    parameter int unsigned NBITS = 32,
    parameter int unsigned LIMW  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        line_i,
    input  logic                        tick_i,
    input  logic                        conv_i,
    input  logic [LIMW-1:0]             limit_i,
    output logic [NBITS-1:0]            bits_o,
    output logic                        bit_valid_o,
    output logic [$clog2(NBITS+1)-1:0]  count_o,
    output logic                        done_o,
    output logic                        err_o
);
    import mdec_pkg::*;

    localparam int unsigned LW = $clog2(3*HALF + 2);
    localparam int unsigned CW = $clog2(NBITS + 1);

    run_kind_t     kind;
    logic          start;
    logic          run_end;
    logic          run_lvl;
    logic [LW-1:0] run_len;
    logic          flush;
    logic          pair_err;

    mdec_frame_ctl #(.HALF(HALF), .LW(LW), .SW(LIMW)) ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .line_i     (line_i),
        .limit_i    (limit_i),
        .kind_i     (kind),
        .pair_err_i (pair_err),
        .start_o    (start),
        .run_end_o  (run_end),
        .run_lvl_o  (run_lvl),
        .run_len_o  (run_len),
        .flush_o    (flush),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    mdec_run_class #(.HALF(HALF), .TOL(TOL), .LW(LW)) class_i (
        .len_i  (run_len),
        .kind_o (kind)
    );

    mdec_bit_asm #(.NBITS(NBITS), .CW(CW)) asm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_i     (conv_i),
        .start_i    (start),
        .run_end_i  (run_end),
        .kind_i     (kind),
        .run_lvl_i  (run_lvl),
        .flush_i    (flush),
        .pair_err_o (pair_err),
        .bits_o     (bits_o),
        .count_o    (count_o),
        .valid_o    (bit_valid_o)
    );
endmodule

// File: rtl/manch_os_decoder_chk.sv
// Port-level checker for the Manchester decoder, bound to every instance.
// Assumes only the top-level port behaviour stated in the requirements.
module manch_os_decoder_chk #(
    parameter int unsigned NBITS = 32,
    parameter int unsigned CW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic [NBITS-1:0] bits_o,
    input logic             bit_valid_o,
    input logic [CW-1:0]    count_o,
    input logic             done_o,
    input logic             err_o
);
    localparam logic [CW-1:0] CMAX = CW'(NBITS);

    // R7: each valid pulse comes with a count step or a saturated count
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> (count_o == $past(count_o) + 1'b1) || (count_o == CMAX));

    // R7: the count never passes the register width
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CMAX);

    // R10: the error flag rises only together with frame end
    a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

    // R10: no bits are reported while the error flag stands
    a_r10_no_bits_in_error: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !bit_valid_o);

    // R3: a cycle without a tick changes nothing at the outputs
    a_r3_quiet_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !bit_valid_o && !done_o && $stable(bits_o));
endmodule

bind manch_os_decoder manch_os_decoder_chk #(.NBITS(NBITS), .CW(CW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bits_o      (bits_o),
    .bit_valid_o (bit_valid_o),
    .count_o     (count_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/manch_os_decoder_tb_top.sv
// Self-checking bench: table of frames plus directed reset and corner tests.
module manch_os_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    typedef struct packed {
        logic        conv;
        logic [5:0]  nb;
        logic [31:0] data;
        logic [3:0]  hl;
        logic [7:0]  lim;
        logic [5:0]  ecnt;
        logic [31:0] ebits;
        logic        eerr;
    } vec_t;

    // conv, bits, data, samples per half, limit, exp count, exp bits, exp err
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'd8,  32'h35,  4'd6, 8'd255, 6'd8,  32'h35,  1'b0}, // R5 R6 conv 0
        '{1'b1, 6'd8,  32'hA6,  4'd6, 8'd255, 6'd8,  32'hA6,  1'b0}, // R5 R6 conv 1
        '{1'b0, 6'd8,  32'h00,  4'd6, 8'd255, 6'd8,  32'h00,  1'b0}, // R8 final bit flushed
        '{1'b1, 6'd12, 32'hFFF, 4'd6, 8'd255, 6'd12, 32'hFFF, 1'b0}, // R8 flush, conv 1
        '{1'b0, 6'd10, 32'h155, 4'd5, 8'd255, 6'd10, 32'h155, 1'b0}, // R4 short halves
        '{1'b1, 6'd10, 32'h2CB, 4'd7, 8'd255, 6'd10, 32'h2CB, 1'b0}, // R4 long halves
        '{1'b0, 6'd8,  32'h00,  4'd6, 8'd29,  6'd2,  32'h0,   1'b0}, // R9 limit cuts
        '{1'b0, 6'd8,  32'h35,  4'd9, 8'd255, 6'd0,  32'h0,   1'b1}, // R4 run too long
        '{1'b1, 6'd8,  32'hA6,  4'd3, 8'd255, 6'd0,  32'h0,   1'b1}, // R4 run too short
        '{1'b1, 6'd12, 32'hFFF, 4'd6, 8'd40,  6'd3,  32'h7,   1'b0}, // R9 limit cuts
        '{1'b0, 6'd8,  32'h35,  4'd6, 8'd255, 6'd8,  32'h35,  1'b0}  // R10 err cleared
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        line_i;
    logic        tick_i;
    logic        conv_i;
    logic [7:0]  limit_i;
    logic [31:0] bits_o;
    logic        bit_valid_o;
    logic [5:0]  count_o;
    logic        done_o;
    logic        err_o;

    int nchk = 0;
    int nfail = 0;
    int ndone_all = 0;
    int nvalid = 0;
    logic        cap_ok = 1'b0;
    logic [31:0] cap_bits = '0;
    logic [5:0]  cap_cnt = '0;
    logic        cap_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    manch_os_decoder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_i),
        .tick_i      (tick_i),
        .conv_i      (conv_i),
        .limit_i     (limit_i),
        .bits_o      (bits_o),
        .bit_valid_o (bit_valid_o),
        .count_o     (count_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (done_o) ndone_all <= ndone_all + 1;
            if (!cap_ok && bit_valid_o) nvalid <= nvalid + 1;
            if (!cap_ok && done_o) begin
                cap_ok   <= 1'b1;
                cap_bits <= bits_o;
                cap_cnt  <= count_o;
                cap_err  <= err_o;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic samp(input logic v, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); line_i = v; tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic arm();
        @(negedge clk);
        cap_ok = 1'b0;
        nvalid = 0;
    endtask

    task automatic send(input vec_t v);
        conv_i  = v.conv;
        limit_i = v.lim;
        samp(1'b1, 5);
        arm();
        for (int i = int'(v.nb) - 1; i >= 0; i--) begin
            logic fh;
            fh = v.conv ? !v.data[i] : v.data[i];
            samp(fh, int'(v.hl));
            samp(!fh, int'(v.hl));
        end
        samp(1'b1, 30);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; line_i = 1'b0; tick_i = 1'b0; conv_i = 1'b0; limit_i = 8'd255;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(bits_o == 0, "R1 bits", bits_o, 0);
        check(count_o == 0 && bit_valid_o == 0, "R1 count/valid", {count_o, bit_valid_o}, 0);
        check(done_o == 0 && err_o == 0, "R1 done/err", {done_o, err_o}, 0);

        // R2: low out of reset, then high: no frame may start
        samp(1'b0, 30);
        samp(1'b1, 30);
        check(ndone_all == 0, "R2 no frame from low start", ndone_all, 0);

        // R3: low levels only in cycles without tick
        for (int g = 0; g < 8; g++) begin
            @(negedge clk); line_i = 1'b1; tick_i = 1'b1;
            @(negedge clk); line_i = 1'b0; tick_i = 1'b0;
        end
        samp(1'b1, 30);
        check(ndone_all == 0, "R3 off-tick glitches ignored", ndone_all, 0);
        check(bits_o == 0, "R3 bits untouched", bits_o, 0);

        // Table of frames
        for (int n = 0; n < NV; n++) begin
            send(VECS[n]);
            check(cap_ok == 1'b1, "R8/R9 frame end seen", cap_ok, 1);
            check(cap_cnt == VECS[n].ecnt, "R7 bit count", cap_cnt, VECS[n].ecnt);
            check(nvalid == int'(VECS[n].ecnt), "R7 valid pulses", nvalid, VECS[n].ecnt);
            check(cap_bits == VECS[n].ebits, "R5/R6 decoded bits", cap_bits, VECS[n].ebits);
            check(cap_err == VECS[n].eerr, "R4/R10 error flag", cap_err, VECS[n].eerr);
        end

        // R11: two half-bits low at a bit start, then R10 stickiness
        conv_i = 1'b0; limit_i = 8'd255;
        samp(1'b1, 5);
        arm();
        samp(1'b0, 12);
        samp(1'b1, 30);
        check(cap_ok == 1'b1 && cap_err == 1'b1, "R11 no mid-bit transition", {cap_ok, cap_err}, 2'b11);
        check(cap_cnt == 0, "R11 no bits", cap_cnt, 0);
        check(err_o == 1'b1, "R10 error held", err_o, 1);
        send(VECS[0]);
        check(cap_err == 1'b0 && err_o == 1'b0, "R10 error cleared by start", {cap_err, err_o}, 0);
        check(cap_bits == 32'h35, "R6 bits after error", cap_bits, 32'h35);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule